// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional 8-bit ports, A and B. Each port has its own capture register, loaded on the rising edge of that port's capture clock. Each direction of transfer has its own source select. The select decides whether the far port is driven with the value currently on the near port (live transfer) or with what the near port's register holds (stored transfer). Neither path inverts the data.

Each direction has its own output enable. The enable onto B is active-high and the enable onto A is active-low. When an enable is inactive, the block leaves that port in high impedance, so an outside agent can drive it.

With these controls the block can pass data through in real time in either direction. It can also store bus data without driving anything, or replay stored data onto either port later. Both ports may be driven at once only when both directions take their data from the registers.

Top module: `dual_bus_reg_xcvr`

## Requirements
- R1: Both ports are 8 bits wide, and every transfer path is non-inverting: a value v taken from one side appears as exactly v on the other.
- R2: On each rising edge of `a_cap_clk` while `rst_n` is high, the A-side register loads the value present on `port_a`.
- R3: On each rising edge of `b_cap_clk` while `rst_n` is high, the B-side register loads the value present on `port_b`.
- R4: The two registers are independent: an edge on one capture clock leaves the other register's contents unchanged.
- R5: When `b_src_stored` = 0 and the drive onto B is enabled, `port_b` follows the live `port_a`. When `b_src_stored` = 1, `port_b` carries the A-side register.
- R6: When `a_src_stored` = 0 and the drive onto A is enabled, `port_a` follows the live `port_b`. When `a_src_stored` = 1, `port_a` carries the B-side register.
- R7: `port_b` is driven only while `b_drive_en` = 1, and `port_a` only while `a_drive_en_n` = 0. Otherwise the port is released to high impedance.
- R8: With both ports enabled and both selects at 1, `port_a` carries the B-side register and `port_b` carries the A-side register at the same time.
- R9: A register can capture its port while this block is the one driving that port, and it then stores the driven value.
- R10: A capture edge while `rst_n` is low clears that register to zero. While `rst_n` is low, neither port is driven, whatever the enables say.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Synchronous active-low reset; also blocks all port drive |
| a_cap_clk | input | 1 | Rising edge loads port A into the A-side register |
| b_cap_clk | input | 1 | Rising edge loads port B into the B-side register |
| b_src_stored | input | 1 | Source for port B: 0 live port A, 1 A-side register |
| a_src_stored | input | 1 | Source for port A: 0 live port B, 1 B-side register |
| b_drive_en | input | 1 | Active-high enable of the drive onto port B |
| a_drive_en_n | input | 1 | Active-low enable of the drive onto port A |
| port_a | inout | 8 | Bidirectional bus A |
| port_b | inout | 8 | Bidirectional bus B |

## Verification
The hardest case to reach is a register that captures a value the block is driving itself, because the content of a register can be seen only by replaying it onto a port. The bench drives A from outside with live transfer onto B enabled, and pulses the B capture clock. It then turns off the B drive, releases A, and replays the B register onto A. High impedance cannot be observed directly. To show that a port is released, the bench drives its own pattern onto it and reads that pattern back unchanged.

// File: rtl/xcvr_pkg.sv
// Package: shared width and source-select encoding for the transceiver.
// Assumes: all data paths in the block share one width.
package xcvr_pkg;

    localparam int unsigned XCVR_WIDTH = 8;

    // Source for a driven port: the live far port, or the stored register.
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

endpackage

// File: rtl/xcvr_store_reg.sv
// Module: xcvr_store_reg
// Capture register for one port. It loads the port value on the rising
// edge of its own clock and clears synchronously while rst_n is low.
// Assumes: the port is resolved (driven by someone) at each capture edge.
module xcvr_store_reg #(
    parameter int unsigned WIDTH = xcvr_pkg::XCVR_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Purpose: capture the port value, or clear it under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2 / R3: every enabled edge stores exactly what was on the port.
    assert_capture_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> q == $past(d));

endmodule

// File: rtl/xcvr_path_sel.sv
// Module: xcvr_path_sel
// One transfer direction: selects live or stored data and turns the raw
// output enable into a drive request. The ENABLE_ACTIVE_LOW parameter
// chooses the polarity of the enable.
// Assumes: the caller places the tri-state buffer on the drive request.
module xcvr_path_sel #(
    parameter int unsigned WIDTH             = xcvr_pkg::XCVR_WIDTH,
    parameter bit          ENABLE_ACTIVE_LOW = 1'b0
) (
    input  logic             rst_n,
    input  logic [WIDTH-1:0] live_val,
    input  logic [WIDTH-1:0] stored_val,
    input  xcvr_pkg::src_sel_e src_sel,
    input  logic             oe_raw,
    output logic [WIDTH-1:0] drv_val,
    output logic             drv_en
);

    logic oe_active;

    // Purpose: normalise the enable polarity for this direction.
    generate
        if (ENABLE_ACTIVE_LOW) begin : g_low
            assign oe_active = ~oe_raw;
        end else begin : g_high
            assign oe_active = oe_raw;
        end
    endgenerate

    // Purpose: choose the data source and block drive while in reset.
    always_comb begin
        drv_val = (src_sel == xcvr_pkg::SRC_STORED) ? stored_val : live_val;
        drv_en  = oe_active & rst_n;
    end

endmodule

// File: rtl/dual_bus_reg_xcvr.sv
// Module: dual_bus_reg_xcvr (top)
// Two-port registered transceiver. Each port has a capture register on
// its own clock. Each direction has a live/stored select and an output
// enable: active-high for B, active-low for A.
// Assumes: both ports are driven at once only in stored mode on both sides.
module dual_bus_reg_xcvr #(
    parameter int unsigned WIDTH = xcvr_pkg::XCVR_WIDTH
) (
    input  logic             rst_n,
    input  logic             a_cap_clk,
    input  logic             b_cap_clk,
    input  logic             b_src_stored,
    input  logic             a_src_stored,
    input  logic             b_drive_en,
    input  logic             a_drive_en_n,
    inout  wire [WIDTH-1:0]  port_a,
    inout  wire [WIDTH-1:0]  port_b
);

    logic [WIDTH-1:0] reg_a_q;
    logic [WIDTH-1:0] reg_b_q;
    logic [WIDTH-1:0] to_b_val;
    logic [WIDTH-1:0] to_a_val;
    logic             to_b_en;
    logic             to_a_en;
    xcvr_pkg::src_sel_e sel_to_b;
    xcvr_pkg::src_sel_e sel_to_a;

    // Purpose: map the raw select pins onto the shared encoding.
    assign sel_to_b = xcvr_pkg::src_sel_e'(b_src_stored);
    assign sel_to_a = xcvr_pkg::src_sel_e'(a_src_stored);

    // A-side register, loaded from port A.
    xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_a (
        .clk(a_cap_clk), .rst_n(rst_n), .d(port_a), .q(reg_a_q)
    );

    // B-side register, loaded from port B.
    xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_b (
        .clk(b_cap_clk), .rst_n(rst_n), .d(port_b), .q(reg_b_q)
    );

    // Direction A to B, enable active-high.
    xcvr_path_sel #(.WIDTH(WIDTH), .ENABLE_ACTIVE_LOW(1'b0)) u_path_ab (
        .rst_n(rst_n), .live_val(port_a), .stored_val(reg_a_q),
        .src_sel(sel_to_b), .oe_raw(b_drive_en),
        .drv_val(to_b_val), .drv_en(to_b_en)
    );

    // Direction B to A, enable active-low.
    xcvr_path_sel #(.WIDTH(WIDTH), .ENABLE_ACTIVE_LOW(1'b1)) u_path_ba (
        .rst_n(rst_n), .live_val(port_b), .stored_val(reg_b_q),
        .src_sel(sel_to_a), .oe_raw(a_drive_en_n),
        .drv_val(to_a_val), .drv_en(to_a_en)
    );

    // Purpose: per-bit tri-state buffers onto both ports.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign port_b[i] = to_b_en ? to_b_val[i] : 1'bz;
            assign port_a[i] = to_a_en ? to_a_val[i] : 1'bz;
        end
    endgenerate

    // R8: driving both ports is legal only with both sides in stored mode.
    assert_no_live_loop_R8: assert property (@(posedge a_cap_clk) disable iff (!rst_n)
        (to_a_en && to_b_en) |-> (b_src_stored && a_src_stored));

    // R5: in stored mode with drive on, port B shows the A-side register.
    assert_replay_b_R5: assert property (@(posedge b_cap_clk) disable iff (!rst_n)
        (b_drive_en && b_src_stored) |-> port_b == reg_a_q);

    // R6: in stored mode with drive on, port A shows the B-side register.
    assert_replay_a_R6: assert property (@(posedge a_cap_clk) disable iff (!rst_n)
        (!a_drive_en_n && a_src_stored) |-> port_a == reg_b_q);

endmodule

// File: tb/test_dual_bus_reg_xcvr.sv
// Directed bench: one task per scenario, each checking its own results.
// A released port is shown by an outside pattern reading back intact.
module test_dual_bus_reg_xcvr;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_cap_clk = 1'b0, b_cap_clk = 1'b0;
    logic b_src_stored = 1'b0, a_src_stored = 1'b0;
    logic b_drive_en = 1'b0, a_drive_en_n = 1'b1;
    logic [W-1:0] a_ext = '0, b_ext = '0;
    logic a_ext_on = 1'b0, b_ext_on = 1'b0;
    wire  [W-1:0] port_a, port_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    assign port_a = a_ext_on ? a_ext : 'z;
    assign port_b = b_ext_on ? b_ext : 'z;

    dual_bus_reg_xcvr i_dual_bus_reg_xcvr (
        .rst_n(rst_n), .a_cap_clk(a_cap_clk), .b_cap_clk(b_cap_clk),
        .b_src_stored(b_src_stored), .a_src_stored(a_src_stored),
        .b_drive_en(b_drive_en), .a_drive_en_n(a_drive_en_n),
        .port_a(port_a), .port_b(port_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_a();
        #1 a_cap_clk = 1'b1; #(CLK_PERIOD/2) a_cap_clk = 1'b0; #(CLK_PERIOD/2);
    endtask

    task automatic pulse_b();
        #1 b_cap_clk = 1'b1; #(CLK_PERIOD/2) b_cap_clk = 1'b0; #(CLK_PERIOD/2);
    endtask

    task automatic idle();
        b_drive_en = 1'b0; a_drive_en_n = 1'b1; a_ext_on = 1'b0; b_ext_on = 1'b0; #1;
    endtask

    // Load the A-side register with v, with all drives off.
    task automatic load_a(input logic [W-1:0] v);
        idle(); a_ext = v; a_ext_on = 1'b1; pulse_a(); a_ext_on = 1'b0; #1;
    endtask

    task automatic load_b(input logic [W-1:0] v);
        idle(); b_ext = v; b_ext_on = 1'b1; pulse_b(); b_ext_on = 1'b0; #1;
    endtask

    // Read the A-side register by replaying it onto B.
    task automatic read_a(output logic [W-1:0] v);
        idle(); b_src_stored = 1'b1; b_drive_en = 1'b1; #2 v = port_b; b_drive_en = 1'b0; #1;
    endtask

    task automatic read_b(output logic [W-1:0] v);
        idle(); a_src_stored = 1'b1; a_drive_en_n = 1'b0; #2 v = port_a; a_drive_en_n = 1'b1; #1;
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        // R10: no drive while rst_n is low, even with both enables on.
        rst_n = 1'b0; b_drive_en = 1'b1; a_drive_en_n = 1'b0;
        a_ext = 8'h3C; b_ext = 8'hC3; a_ext_on = 1'b1; b_ext_on = 1'b1;
        pulse_a(); pulse_b();
        #1 check("R10 A released in reset", port_a, 8'h3C);
        check("R10 B released in reset", port_b, 8'hC3);
        idle(); rst_n = 1'b1; #1;
        read_a(v); check("R10 A reg cleared", v, 8'h00);
        read_b(v); check("R10 B reg cleared", v, 8'h00);
    endtask

    task automatic t_live_ab();
        logic [W-1:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h01};
        idle(); b_src_stored = 1'b0; b_drive_en = 1'b1; a_ext_on = 1'b1;
        foreach (pats[k]) begin
            a_ext = pats[k]; #2 check("R1 R5 live A to B", port_b, pats[k]);
        end
        idle();
    endtask

    task automatic t_live_ba();
        logic [W-1:0] pats [3] = '{8'h5A, 8'h80, 8'h7E};
        idle(); a_src_stored = 1'b0; a_drive_en_n = 1'b0; b_ext_on = 1'b1;
        foreach (pats[k]) begin
            b_ext = pats[k]; #2 check("R1 R6 live B to A", port_a, pats[k]);
        end
        idle();
    endtask

    task automatic t_capture();
        logic [W-1:0] v;
        // R2 and R3: capture while the block drives nothing.
        load_a(8'h96); read_a(v); check("R2 capture A", v, 8'h96);
        load_b(8'h69); read_b(v); check("R3 capture B", v, 8'h69);
    endtask

    task automatic t_independent();
        logic [W-1:0] v;
        load_a(8'h11); load_b(8'h22);
        load_a(8'h33); read_b(v); check("R4 B kept after A edge", v, 8'h22);
        load_b(8'h44); read_a(v); check("R4 A kept after B edge", v, 8'h33);
    endtask

    task automatic t_stored();
        load_a(8'hE1); load_b(8'h1E);
        // R5: stored data reaches B while port A carries something else.
        idle(); a_ext = 8'h00; a_ext_on = 1'b1; b_src_stored = 1'b1; b_drive_en = 1'b1;
        #2 check("R5 stored A to B", port_b, 8'hE1);
        b_src_stored = 1'b0; #2 check("R5 select back to live", port_b, 8'h00);
        idle(); b_ext = 8'hFF; b_ext_on = 1'b1; a_src_stored = 1'b1; a_drive_en_n = 1'b0;
        #2 check("R6 stored B to A", port_a, 8'h1E);
        idle();
    endtask

    task automatic t_disable();
        // R7: each port is released while its enable is inactive.
        idle(); a_ext = 8'h0F; a_ext_on = 1'b1; b_ext = 8'hF0; b_ext_on = 1'b1;
        b_src_stored = 1'b1; a_src_stored = 1'b1;
        #2 check("R7 B released", port_b, 8'hF0);
        check("R7 A released", port_a, 8'h0F);
        idle();
    endtask

    task automatic t_both_stored();
        load_a(8'hAB); load_b(8'hCD);
        idle(); b_src_stored = 1'b1; a_src_stored = 1'b1;
        b_drive_en = 1'b1; a_drive_en_n = 1'b0;
        #2 check("R8 both stored, A", port_a, 8'hCD);
        check("R8 both stored, B", port_b, 8'hAB);
        idle();
    endtask

    task automatic t_loopback();
        logic [W-1:0] v;
        load_b(8'h00);
        // R9: the B register captures the value the block drives onto B.
        idle(); a_ext = 8'h5C; a_ext_on = 1'b1; b_src_stored = 1'b0; b_drive_en = 1'b1;
        pulse_b();
        read_b(v); check("R9 loop-back capture", v, 8'h5C);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_live_ab();
        t_live_ba();
        t_capture();
        t_independent();
        t_stored();
        t_disable();
        t_both_stored();
        t_loopback();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule